// File: doc/BRIEF.md
# Multithreaded Thread Select Unit

This block decides, once per clock, which hardware thread context feeds the next fetch or issue slot of a multithreaded pipeline. It watches two per-thread inputs. One says whether the thread can issue now. The other says whether the thread is held up by a long-latency event such as a miss in a lower cache level. From these it produces a registered thread number, a valid flag and a one-cycle flush request.

The unit has two scheduling modes. In interleaved mode the grant moves every cycle, in round-robin order, and passes over any thread that cannot issue. A designated thread can be given first claim on every slot it is able to use. In switch-on-stall mode the unit stays on one thread until that thread reports a long stall. It then moves to another thread. The replacement is chosen by the designated thread when that thread is usable, and otherwise by per-thread weights. Each such switch costs a pipeline flush and a fixed number of refill bubbles.

A thread is called eligible in a cycle when its ready bit is 1 and its long-stall bit is 0. Each thread owns a WGT_W-bit field of the weight bus: thread t owns bits t*WGT_W to t*WGT_W+WGT_W-1. A larger weight value means higher priority. REFILL_CYC must be at least 1.

Top module: `thread_select_unit`

## Requirements
- R1: While rst_n is low, and after it is released until the first clock edge, sel_tid is 0, sel_valid is 0 and flush_req is 0. The unit starts in interleaved mode with its rotation pointer at thread 0.
- R2: In interleaved mode, the outputs are registered from the inputs sampled at the same clock edge. If the designated thread does not take the slot, the grant goes to the first eligible thread found by searching upward from the rotation pointer, wrapping at NUM_THR. After such a grant the pointer moves to the granted thread plus one, modulo NUM_THR.
- R3: In interleaved mode with every thread eligible and pref_en low, the grants run 0, 1, 2, …, NUM_THR-1 and then repeat. Each thread is served once in every NUM_THR consecutive cycles.
- R4: In interleaved mode with no eligible thread, sel_valid goes low in the next cycle, sel_tid keeps its value, and the rotation pointer does not move.
- R5: In interleaved mode, when pref_en is 1 and thread pref_tid is eligible, that thread is granted and the rotation pointer does not move. When the designated thread is not eligible, the grant follows R2.
- R6: In switch-on-stall mode, while the current thread's long-stall bit is 0, sel_tid stays on that thread and sel_valid equals its ready bit. A short stall (ready low, long stall low) never causes a switch.
- R7: In switch-on-stall mode, a long stall on the current thread causes a switch when some other thread is eligible. The target is pref_tid if pref_en is 1, pref_tid is eligible and pref_tid differs from the current thread. Otherwise the target is the eligible thread with the largest weight, with ties going to the first such thread found searching upward from the current thread plus one.
- R8: On a switch, sel_tid shows the new thread and flush_req is 1 for exactly one cycle. sel_valid is low in that cycle and in the REFILL_CYC cycles after it. sel_tid does not change during those cycles.
- R9: In switch-on-stall mode, a long stall on the current thread with no other eligible thread causes no switch and no flush. The unit stays on the current thread with sel_valid low.
- R10: coarse_mode is sampled only at clock edges where no switch happens and no refill bubble is pending. The sampled mode governs decisions from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_ready | input | NUM_THR | Per-thread ability to issue this cycle |
| thr_long_stall | input | NUM_THR | Per-thread long-latency stall indication |
| coarse_mode | input | 1 | 0 = interleave every cycle, 1 = switch on long stall |
| pref_en | input | 1 | Enables the designated-thread override |
| pref_tid | input | TID_W | Number of the designated thread |
| thr_weight | input | NUM_THR*WGT_W | Per-thread switch priority weights |
| sel_tid | output | TID_W | Selected thread number |
| sel_valid | output | 1 | Selected thread may issue this cycle |
| flush_req | output | 1 | One-cycle pipeline flush/freeze request on a switch |

## Verification
Interleaved selection is driven in four ways: all threads eligible, sparse ready masks, long-stall bits that mask out ready threads, and an empty mask. Together these separate correct rotation and skipping from pointer drift and from holding the last grant. The designated-thread tests turn that thread's eligibility on and off, which shows whether the override leaves the rotation pointer untouched. Switch-on-stall tests cover five cases: a short stall, which must not switch; a long stall resolved by weight with tied maxima; a long stall resolved by the designated thread; a long stall with no alternative; and a mode change requested during the refill bubbles. A long run of random inputs then mixes all of these cases.

// File: rtl/thrsel_pkg.sv
package thrsel_pkg;

  typedef enum logic {
    MODE_FINE   = 1'b0,
    MODE_COARSE = 1'b1
  } sel_mode_e;

endpackage

// File: rtl/thrsel_rr_pick.sv
// Rotating first-eligible search starting at a base index.
module thrsel_rr_pick #(
  parameter int NUM_THR = 4,
  parameter int TID_W   = 2
) (
  input  logic [NUM_THR-1:0] req_i,
  input  logic [TID_W-1:0]   base_i,
  output logic               hit_o,
  output logic [TID_W-1:0]   idx_o
);

  function automatic int wrap_idx(input int v);
    return v % NUM_THR;
  endfunction

  logic [TID_W-1:0] cand;

  always_comb begin
    hit_o = 1'b0;
    idx_o = base_i;
    cand  = base_i;
    for (int i = 0; i < NUM_THR; i++) begin
      cand = TID_W'(wrap_idx(int'(base_i) + i));
      if (!hit_o && req_i[cand]) begin
        hit_o = 1'b1;
        idx_o = cand;
      end
    end
  end

endmodule

// File: rtl/thrsel_wgt_pick.sv
// Highest-weight search; ties resolved by rotation order from base.
module thrsel_wgt_pick #(
  parameter int NUM_THR = 4,
  parameter int TID_W   = 2,
  parameter int WGT_W   = 3
) (
  input  logic [NUM_THR-1:0]       req_i,
  input  logic [NUM_THR*WGT_W-1:0] weight_i,
  input  logic [TID_W-1:0]         base_i,
  output logic                     hit_o,
  output logic [TID_W-1:0]         idx_o
);

  function automatic int wrap_idx(input int v);
    return v % NUM_THR;
  endfunction

  logic [WGT_W-1:0] w_arr [NUM_THR];

  for (genvar g = 0; g < NUM_THR; g++) begin : g_unpack
    assign w_arr[g] = weight_i[g*WGT_W +: WGT_W];
  end

  logic [TID_W-1:0] cand;
  logic [WGT_W-1:0] best_w;

  always_comb begin
    hit_o  = 1'b0;
    idx_o  = base_i;
    cand   = base_i;
    best_w = '0;
    for (int i = 0; i < NUM_THR; i++) begin
      cand = TID_W'(wrap_idx(int'(base_i) + i));
      if (req_i[cand] && (!hit_o || (w_arr[cand] > best_w))) begin
        hit_o  = 1'b1;
        idx_o  = cand;
        best_w = w_arr[cand];
      end
    end
  end

endmodule

// File: rtl/thrsel_refill_ctr.sv
// Counts refill bubbles after a thread switch.
module thrsel_refill_ctr #(
  parameter int REFILL_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic busy_o
);

  localparam int CNT_W = (REFILL_CYC > 0) ? $clog2(REFILL_CYC + 1) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign busy_o = (cnt_q != '0);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = CNT_W'(REFILL_CYC);
    end else if (busy_o) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/thread_select_unit.sv
module thread_select_unit
  import thrsel_pkg::*;
#(
  parameter int NUM_THR    = 4,
  parameter int WGT_W      = 3,
  parameter int REFILL_CYC = 3,
  localparam int TID_W     = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_THR-1:0]       thr_ready,
  input  logic [NUM_THR-1:0]       thr_long_stall,
  input  logic                     coarse_mode,
  input  logic                     pref_en,
  input  logic [TID_W-1:0]         pref_tid,
  input  logic [NUM_THR*WGT_W-1:0] thr_weight,
  output logic [TID_W-1:0]         sel_tid,
  output logic                     sel_valid,
  output logic                     flush_req
);

  function automatic int wrap_idx(input int v);
    return v % NUM_THR;
  endfunction

  // state
  logic [TID_W-1:0] tid_q, tid_d, ptr_q, ptr_d;
  logic             valid_q, valid_d, flush_q, flush_d;
  logic             tid_en, ptr_en, mode_en;
  sel_mode_e        mode_q, mode_d;

  // per-thread qualification
  logic [NUM_THR-1:0] elig, cur_oh, sw_cand;

  for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
    assign elig[g]    = thr_ready[g] & ~thr_long_stall[g];
    assign cur_oh[g]  = (tid_q == TID_W'(g));
    assign sw_cand[g] = elig[g] & ~cur_oh[g];
  end

  logic pref_in_rng, pref_ok, pref_sw_ok;
  assign pref_in_rng = (int'(pref_tid) < NUM_THR);
  assign pref_ok     = pref_en && pref_in_rng && elig[pref_tid];
  assign pref_sw_ok  = pref_ok && (pref_tid != tid_q);

  // interleave search
  logic             rr_hit;
  logic [TID_W-1:0] rr_idx;

  thrsel_rr_pick #(
    .NUM_THR(NUM_THR),
    .TID_W  (TID_W)
  ) u_rr (
    .req_i (elig),
    .base_i(ptr_q),
    .hit_o (rr_hit),
    .idx_o (rr_idx)
  );

  // switch target search
  logic [TID_W-1:0] sw_base;
  logic             wg_hit;
  logic [TID_W-1:0] wg_idx;

  assign sw_base = TID_W'(wrap_idx(int'(tid_q) + 1));

  thrsel_wgt_pick #(
    .NUM_THR(NUM_THR),
    .TID_W  (TID_W),
    .WGT_W  (WGT_W)
  ) u_wgt (
    .req_i   (sw_cand),
    .weight_i(thr_weight),
    .base_i  (sw_base),
    .hit_o   (wg_hit),
    .idx_o   (wg_idx)
  );

  // refill bubbles
  logic sw_load, refill_busy;

  thrsel_refill_ctr #(
    .REFILL_CYC(REFILL_CYC)
  ) u_refill (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(sw_load),
    .busy_o(refill_busy)
  );

  // next-state
  always_comb begin
    tid_en  = 1'b0;
    tid_d   = tid_q;
    ptr_en  = 1'b0;
    ptr_d   = ptr_q;
    valid_d = 1'b0;
    flush_d = 1'b0;
    sw_load = 1'b0;

    if (refill_busy) begin
      valid_d = 1'b0;
    end else if (mode_q == MODE_FINE) begin
      if (pref_ok) begin
        tid_en  = 1'b1;
        tid_d   = pref_tid;
        valid_d = 1'b1;
      end else if (rr_hit) begin
        tid_en  = 1'b1;
        tid_d   = rr_idx;
        valid_d = 1'b1;
        ptr_en  = 1'b1;
        ptr_d   = TID_W'(wrap_idx(int'(rr_idx) + 1));
      end
    end else begin
      if (thr_long_stall[tid_q]) begin
        if (pref_sw_ok) begin
          tid_en  = 1'b1;
          tid_d   = pref_tid;
          flush_d = 1'b1;
          sw_load = 1'b1;
        end else if (wg_hit) begin
          tid_en  = 1'b1;
          tid_d   = wg_idx;
          flush_d = 1'b1;
          sw_load = 1'b1;
        end
      end else begin
        valid_d = thr_ready[tid_q];
      end
    end
  end

  assign mode_en = !refill_busy && !sw_load;
  assign mode_d  = coarse_mode ? MODE_COARSE : MODE_FINE;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tid_q   <= '0;
      ptr_q   <= '0;
      valid_q <= 1'b0;
      flush_q <= 1'b0;
      mode_q  <= MODE_FINE;
    end else begin
      valid_q <= valid_d;
      flush_q <= flush_d;
      if (tid_en)  tid_q  <= tid_d;
      if (ptr_en)  ptr_q  <= ptr_d;
      if (mode_en) mode_q <= mode_d;
    end
  end

  assign sel_tid   = tid_q;
  assign sel_valid = valid_q;
  assign flush_req = flush_q;

endmodule

// File: rtl/thread_select_chk.sv
module thread_select_chk #(
  parameter int NUM_THR    = 4,
  parameter int REFILL_CYC = 3,
  localparam int TID_W     = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_THR-1:0] thr_ready,
  input logic [NUM_THR-1:0] thr_long_stall,
  input logic [TID_W-1:0]   sel_tid,
  input logic               sel_valid,
  input logic               flush_req
);

  logic [NUM_THR-1:0] elig_now, elig_q;
  assign elig_now = thr_ready & ~thr_long_stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) elig_q <= '0;
    else        elig_q <= elig_now;
  end

  // R2
  valid_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> elig_q[sel_tid]);

  // R4
  idle_novalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_now == '0) |=> !sel_valid);

  // R8
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !flush_req);

  // R8
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> !sel_valid);

  // R8
  flush_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (!sel_valid && $stable(sel_tid)));

endmodule

bind thread_select_unit thread_select_chk #(
  .NUM_THR   (NUM_THR),
  .REFILL_CYC(REFILL_CYC)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .thr_ready     (thr_ready),
  .thr_long_stall(thr_long_stall),
  .sel_tid       (sel_tid),
  .sel_valid     (sel_valid),
  .flush_req     (flush_req)
);

// File: tb/thread_select_unit_test.sv
module thread_select_unit_test;

  localparam int N  = 4;
  localparam int WW = 3;
  localparam int RF = 3;
  localparam int TW = 2;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  thr_ready;
  logic [N-1:0]  thr_long_stall;
  logic          coarse_mode;
  logic          pref_en;
  logic [TW-1:0] pref_tid;
  logic [N*WW-1:0] thr_weight;
  logic [TW-1:0] sel_tid;
  logic          sel_valid;
  logic          flush_req;

  thread_select_unit #(.NUM_THR(N), .WGT_W(WW), .REFILL_CYC(RF)) uut (
    .clk(clk), .rst_n(rst_n), .thr_ready(thr_ready), .thr_long_stall(thr_long_stall),
    .coarse_mode(coarse_mode), .pref_en(pref_en), .pref_tid(pref_tid),
    .thr_weight(thr_weight), .sel_tid(sel_tid), .sel_valid(sel_valid),
    .flush_req(flush_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk;
  int n_fail;

  // behavioural reference state
  int m_tid, m_ptr, m_cnt;
  bit m_valid, m_flush, m_coarse;

  function automatic int wt(input int t);
    return int'(thr_weight[t*WW +: WW]);
  endfunction

  task automatic model_step();
    bit el[N];
    bit old_busy, sw, found;
    int cur, tgt, bw, base;
    for (int t = 0; t < N; t++) el[t] = thr_ready[t] && !thr_long_stall[t];
    old_busy = (m_cnt != 0);
    sw = 0;
    if (old_busy) begin
      m_cnt--; m_valid = 0; m_flush = 0;
    end else if (!m_coarse) begin
      m_flush = 0;
      if (pref_en && el[pref_tid]) begin
        m_tid = int'(pref_tid); m_valid = 1;
      end else begin
        m_valid = 0; found = 0; base = m_ptr;
        for (int i = 0; i < N; i++) begin
          int c = (base + i) % N;
          if (!found && el[c]) begin
            found = 1; m_tid = c; m_valid = 1; m_ptr = (c + 1) % N;
          end
        end
      end
    end else begin
      cur = m_tid; m_flush = 0;
      if (thr_long_stall[cur]) begin
        tgt = -1;
        if (pref_en && el[pref_tid] && int'(pref_tid) != cur) tgt = int'(pref_tid);
        else begin
          bw = -1;
          for (int i = 1; i < N; i++) begin
            int c = (cur + i) % N;
            if (el[c] && wt(c) > bw) begin tgt = c; bw = wt(c); end
          end
        end
        m_valid = 0;
        if (tgt >= 0) begin
          m_tid = tgt; m_flush = 1; m_cnt = RF; sw = 1;
        end
      end else begin
        m_valid = thr_ready[cur];
      end
    end
    if (!old_busy && !sw) m_coarse = coarse_mode;
  endtask

  task automatic compare(input string req);
    n_chk++;
    if (sel_tid !== TW'(m_tid) || sel_valid !== m_valid || flush_req !== m_flush) begin
      n_fail++;
      $display("FAIL %s: tid/valid/flush actual %0d/%0b/%0b expected %0d/%0b/%0b",
               req, sel_tid, sel_valid, flush_req, m_tid, m_valid, m_flush);
    end
  endtask

  task automatic cyc(input string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(req);
  endtask

  task automatic run(input int n, input string req);
    for (int k = 0; k < n; k++) cyc(req);
  endtask

  task automatic set_w(input int t, input int v);
    thr_weight[t*WW +: WW] = WW'(v);
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual still running, expected finished");
    finish_test();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0;
    thr_ready = '1; thr_long_stall = '0; coarse_mode = 1'b0;
    pref_en = 1'b0; pref_tid = '0; thr_weight = '0;
    m_tid = 0; m_ptr = 0; m_cnt = 0; m_valid = 0; m_flush = 0; m_coarse = 0;

    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    compare("R1");

    // R3: full rotation
    run(9, "R3");

    // R2: sparse masks and long-stall masking
    thr_ready = 4'b1010;             run(4, "R2");
    thr_ready = 4'b0001;             run(2, "R2");
    thr_ready = 4'b1111; thr_long_stall = 4'b0010; run(4, "R2");
    thr_long_stall = 4'b0000;

    // R4: nothing eligible
    thr_ready = 4'b0000;             run(3, "R4");
    thr_ready = 4'b1111; thr_long_stall = 4'b1111; run(2, "R4");
    thr_long_stall = 4'b0000; thr_ready = 4'b0100; run(1, "R4");
    thr_ready = 4'b1111;             run(2, "R4");

    // R5: designated thread override
    pref_en = 1'b1; pref_tid = 2'd2; run(3, "R5");
    thr_ready[2] = 1'b0;             run(3, "R5");
    thr_ready = 4'b1111; pref_en = 1'b0; run(2, "R5");

    // R10 / R6: enter switch-on-stall mode and stay
    coarse_mode = 1'b1;              cyc("R10");
    run(4, "R6");
    thr_ready[m_tid] = 1'b0;         run(2, "R6");
    thr_ready = 4'b1111;             run(1, "R6");

    // R7 / R8: weighted switch with tied maxima
    set_w(0, 1); set_w(1, 5); set_w(2, 2); set_w(3, 5);
    thr_long_stall[m_tid] = 1'b1;    cyc("R7");
    thr_long_stall = '0;             run(RF, "R8");
    run(2, "R8");

    // R7 / R10: designated target, mode change during bubbles
    pref_en = 1'b1; pref_tid = TW'((m_tid + 2) % N);
    thr_long_stall[m_tid] = 1'b1;    cyc("R7");
    thr_long_stall = '0; coarse_mode = 1'b0; run(RF, "R10");
    run(4, "R10");
    pref_en = 1'b0;

    // R9: long stall with no alternative
    coarse_mode = 1'b1;              cyc("R10");
    thr_ready = '0; thr_ready[m_tid] = 1'b1;
    thr_long_stall = '0; thr_long_stall[m_tid] = 1'b1;
    run(3, "R9");
    thr_ready = 4'b1111; thr_long_stall = '0; run(1, "R6");

    // R2: random mix of all modes
    for (int k = 0; k < 600; k++) begin
      thr_ready      = N'($urandom_range(0, 15));
      thr_long_stall = N'($urandom_range(0, 15) & $urandom_range(0, 15));
      pref_en        = ($urandom_range(0, 3) == 0);
      pref_tid       = TW'($urandom_range(0, N - 1));
      if ($urandom_range(0, 19) == 0) coarse_mode = ~coarse_mode;
      if ($urandom_range(0, 9) == 0) thr_weight = (N*WW)'($urandom());
      cyc("R2");
    end

    finish_test();
  end

endmodule